// File: doc/BRIEF.md
# Level-2 Event Fragment Formatter

This block turns one accepted event into a fixed-order stream of 16-bit words for a downstream data concentrator. An upstream stage presents the whole event at once: an event identifier, a 12-bit crossing number, a 2-bit data-state code, up to ten processed samples, a per-sample error flag, a filter sum and a channel address. The block captures all of it in one cycle and then emits it one word per cycle into an output FIFO.

The fragment order is fixed: identifier, crossing word, the data samples, the sum, and a closing address/error word. The number of samples comes from a configuration input. It is sampled when the event is accepted. Emission pauses while the FIFO reports full. A new event is accepted only when the previous fragment has fully left.

Top module: `fragFmtTop`

## Requirements
- R1: While reset is held and right after it is released, `outValid` is 0 and `evtReady` is 1.
- R2: The first word of every fragment equals `evtId` as captured at acceptance.
- R3: The second word is laid out as follows: bits 11:0 hold `evtCrossing`, bits 13:12 hold `evtState`, and bits 15:14 are 0.
- R4: Data words follow in sample order, starting from sample 0 (`evtSamples[15:0]`). Sample k comes from `evtSamples[16k+15:16k]`. The number of data words is N = `cfgBuckets` when it lies in 1..10.
- R5: A `cfgBuckets` value of 0, or of 11 to 15, gives N = 10.
- R6: The word after the last data word equals `evtSum`.
- R7: The last word carries `evtAddr` in bits 14:0. Bit 15 is set only when `evtSampleErr[k]` is 1 for some sample k < N. Error flags of samples that are not emitted have no effect.
- R8: A word is transferred on each rising edge where `outValid` is 1 and `fifoFull` is 0. While `fifoFull` is 1, `outWord` holds, and no word is lost or repeated.
- R9: `evtReady` is 1 exactly when no fragment is in progress. An event is accepted on an edge where `evtValid` and `evtReady` are both 1. Event inputs presented while a fragment is in progress are ignored, and inputs that change after acceptance do not alter the fragment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBuckets | input | 4 | Requested data word count, sampled at acceptance |
| evtValid | input | 1 | Event inputs are valid |
| evtReady | output | 1 | Block idle, can accept an event |
| evtId | input | 16 | Event identifier |
| evtCrossing | input | 12 | Beam crossing number |
| evtState | input | 2 | Data-state code |
| evtSamples | input | 160 | Ten 16-bit samples, sample 0 in the low bits |
| evtSampleErr | input | 10 | Per-sample error flags |
| evtSum | input | 16 | Filter sum |
| evtAddr | input | 15 | Channel address |
| fifoFull | input | 1 | Downstream FIFO full, stalls emission |
| outValid | output | 1 | `outWord` holds a fragment word |
| outWord | output | 16 | Fragment word |

## Verification
The assertions check four rules on every clock:
- `outWord` holds still across a stalled cycle.
- The block never accepts an event while a word is pending.
- The sample index stays below ten and steps by one per transferred data word.
- The block returns to idle right after the closing word leaves.

Only the bench's scenarios can show that word contents match the captured inputs, and that the count clamp and the masking of error flags for samples that are not emitted give the right fragment. They also show that a pseudo-random stall pattern and back-to-back events deliver every word exactly once.

// File: rtl/fragFmtPkg.sv
package fragFmtPkg;
  localparam int WORD_W      = 16;
  localparam int MAX_BUCKETS = 10;
  localparam int BX_W        = 12;
  localparam int DSTATE_W    = 2;
  localparam int CFG_W       = 4;
  localparam int IDX_W       = $clog2(MAX_BUCKETS);
  localparam int ADDR_W      = WORD_W - 1;
  localparam int PAD_W       = WORD_W - BX_W - DSTATE_W;
  localparam int SAMPLES_W   = WORD_W * MAX_BUCKETS;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_BX,
    PH_DATA,
    PH_SUM,
    PH_TRAIL
  } fragPhase_e;

  typedef struct packed {
    logic              load;
    logic              advance;
    logic              outValid;
    fragPhase_e        phase;
    logic [IDX_W-1:0]  bucketIdx;
  } fmtCtrl_t;

  function automatic logic [CFG_W-1:0] clampBuckets(input logic [CFG_W-1:0] req);
    if (req == '0 || req > CFG_W'(MAX_BUCKETS)) return CFG_W'(MAX_BUCKETS);
    return req;
  endfunction
endpackage

// File: rtl/fragFmtCtrl.sv
module fragFmtCtrl
  import fragFmtPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgBuckets,
  input  logic             evtValid,
  input  logic             fifoFull,
  output logic             evtReady,
  output fmtCtrl_t         ctrl
);
  fragPhase_e       phaseQ, phaseD;
  logic [IDX_W-1:0] cntQ, cntD;
  logic [IDX_W-1:0] lastQ, lastD;
  logic [CFG_W-1:0] nEff, nEffM1;
  logic             load, advance, busy;

  assign nEff    = clampBuckets(cfgBuckets);
  assign nEffM1  = nEff - CFG_W'(1);
  assign busy    = (phaseQ != PH_IDLE);
  assign load    = !busy && evtValid;
  assign advance = busy && !fifoFull;

  always_comb begin
    phaseD = phaseQ;
    cntD   = cntQ;
    lastD  = lastQ;
    if (load) begin
      phaseD = PH_HDR;
      cntD   = '0;
      lastD  = nEffM1[IDX_W-1:0];
    end else if (advance) begin
      unique case (phaseQ)
        PH_HDR:   phaseD = PH_BX;
        PH_BX:    begin phaseD = PH_DATA; cntD = '0; end
        PH_DATA:  begin
          if (cntQ == lastQ) phaseD = PH_SUM;
          else               cntD   = cntQ + IDX_W'(1);
        end
        PH_SUM:   phaseD = PH_TRAIL;
        PH_TRAIL: phaseD = PH_IDLE;
        default:  phaseD = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      cntQ   <= '0;
      lastQ  <= '0;
    end else begin
      phaseQ <= phaseD;
      cntQ   <= cntD;
      lastQ  <= lastD;
    end
  end

  assign evtReady       = !busy;
  assign ctrl.load      = load;
  assign ctrl.advance   = advance;
  assign ctrl.outValid  = busy;
  assign ctrl.phase     = phaseQ;
  assign ctrl.bucketIdx = cntQ;

  // R9
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtReady |-> !ctrl.outValid);

  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ < IDX_W'(MAX_BUCKETS));

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_DATA && advance && cntQ != lastQ) |=>
      (phaseQ == PH_DATA && cntQ == $past(cntQ) + IDX_W'(1)));

  // R9
  idle_after_trail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_TRAIL && advance) |=> evtReady);
endmodule

// File: rtl/fragFmtData.sv
module fragFmtData
  import fragFmtPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  fmtCtrl_t            ctrl,
  input  logic [CFG_W-1:0]    cfgBuckets,
  input  logic [WORD_W-1:0]   evtId,
  input  logic [BX_W-1:0]     evtCrossing,
  input  logic [DSTATE_W-1:0] evtState,
  input  logic [SAMPLES_W-1:0] evtSamples,
  input  logic [MAX_BUCKETS-1:0] evtSampleErr,
  input  logic [WORD_W-1:0]   evtSum,
  input  logic [ADDR_W-1:0]   evtAddr,
  output logic [WORD_W-1:0]   outWord
);
  logic [WORD_W-1:0]      idQ, sumQ;
  logic [BX_W-1:0]        bxQ;
  logic [DSTATE_W-1:0]    stateQ;
  logic [ADDR_W-1:0]      addrQ;
  logic                   errQ;
  logic [WORD_W-1:0]      sampleQ [MAX_BUCKETS];
  logic [MAX_BUCKETS-1:0] errHit;
  logic [CFG_W-1:0]       nEff;

  assign nEff = clampBuckets(cfgBuckets);

  for (genvar g = 0; g < MAX_BUCKETS; g++) begin : gSample
    assign errHit[g] = evtSampleErr[g] && (CFG_W'(g) < nEff);
    always_ff @(posedge clk) begin
      if (!rstN)          sampleQ[g] <= '0;
      else if (ctrl.load) sampleQ[g] <= evtSamples[g*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idQ    <= '0;
      sumQ   <= '0;
      bxQ    <= '0;
      stateQ <= '0;
      addrQ  <= '0;
      errQ   <= 1'b0;
    end else if (ctrl.load) begin
      idQ    <= evtId;
      sumQ   <= evtSum;
      bxQ    <= evtCrossing;
      stateQ <= evtState;
      addrQ  <= evtAddr;
      errQ   <= |errHit;
    end
  end

  always_comb begin
    unique case (ctrl.phase)
      PH_HDR:   outWord = idQ;
      PH_BX:    outWord = {{PAD_W{1'b0}}, stateQ, bxQ};
      PH_DATA:  outWord = sampleQ[ctrl.bucketIdx];
      PH_SUM:   outWord = sumQ;
      PH_TRAIL: outWord = {errQ, addrQ};
      default:  outWord = '0;
    endcase
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.outValid && !ctrl.advance) |=> (ctrl.outValid && $stable(outWord)));

  // R9
  load_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |-> !ctrl.outValid);
endmodule

// File: rtl/fragFmtTop.sv
module fragFmtTop
  import fragFmtPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CFG_W-1:0]       cfgBuckets,
  input  logic                   evtValid,
  output logic                   evtReady,
  input  logic [WORD_W-1:0]      evtId,
  input  logic [BX_W-1:0]        evtCrossing,
  input  logic [DSTATE_W-1:0]    evtState,
  input  logic [SAMPLES_W-1:0]   evtSamples,
  input  logic [MAX_BUCKETS-1:0] evtSampleErr,
  input  logic [WORD_W-1:0]      evtSum,
  input  logic [ADDR_W-1:0]      evtAddr,
  input  logic                   fifoFull,
  output logic                   outValid,
  output logic [WORD_W-1:0]      outWord
);
  fmtCtrl_t ctrl;

  fragFmtCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgBuckets (cfgBuckets),
    .evtValid   (evtValid),
    .fifoFull   (fifoFull),
    .evtReady   (evtReady),
    .ctrl       (ctrl)
  );

  fragFmtData u_data (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .cfgBuckets   (cfgBuckets),
    .evtId        (evtId),
    .evtCrossing  (evtCrossing),
    .evtState     (evtState),
    .evtSamples   (evtSamples),
    .evtSampleErr (evtSampleErr),
    .evtSum       (evtSum),
    .evtAddr      (evtAddr),
    .outWord      (outWord)
  );

  assign outValid = ctrl.outValid;
endmodule

// File: tb/fragFmtTop_bench.sv
`timescale 1ns/1ps
module fragFmtTop_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   cfgBuckets = '0;
  logic         evtValid = 1'b0;
  logic         evtReady;
  logic [15:0]  evtId = '0;
  logic [11:0]  evtCrossing = '0;
  logic [1:0]   evtState = '0;
  logic [159:0] evtSamples = '0;
  logic [9:0]   evtSampleErr = '0;
  logic [15:0]  evtSum = '0;
  logic [14:0]  evtAddr = '0;
  logic         fifoFull = 1'b0;
  logic         outValid;
  logic [15:0]  outWord;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int pushed = 0;
  int popped = 0;
  bit stallMode = 0;
  bit forceFull = 0;
  bit lastAccept = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  fragFmtTop u_fragFmtTop (
    .clk(clk), .rstN(rstN), .cfgBuckets(cfgBuckets), .evtValid(evtValid),
    .evtReady(evtReady), .evtId(evtId), .evtCrossing(evtCrossing),
    .evtState(evtState), .evtSamples(evtSamples), .evtSampleErr(evtSampleErr),
    .evtSum(evtSum), .evtAddr(evtAddr), .fifoFull(fifoFull),
    .outValid(outValid), .outWord(outWord)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic pushWord(input logic [15:0] w, input string tag);
    expQ.push_back(w);
    tagQ.push_back(tag);
    pushed++;
  endtask

  // Reference model: builds the expected fragment from the inputs at acceptance.
  task automatic acceptEvent();
    int n;
    bit clamped;
    bit err;
    clamped = (cfgBuckets == 0) || (cfgBuckets > 10);
    n = clamped ? 10 : int'(cfgBuckets);
    err = 0;
    pushWord(evtId, "R2");
    pushWord({2'b00, evtState, evtCrossing}, "R3");
    for (int i = 0; i < n; i++) begin
      pushWord(evtSamples[i*16 +: 16], clamped ? "R5" : "R4");
      if (evtSampleErr[i]) err = 1;
    end
    pushWord(evtSum, "R6");
    pushWord({err, evtAddr}, "R7");
  endtask

  always @(posedge clk) begin
    lastAccept <= 0;
    if (!rstN) begin
      expQ.delete();
      tagQ.delete();
    end else if (expQ.size() > 0 && !fifoFull) begin
      void'(expQ.pop_front());
      void'(tagQ.pop_front());
      popped++;
    end else if (expQ.size() == 0 && evtValid) begin
      acceptEvent();
      lastAccept <= 1;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    fifoFull <= stallMode ? (lfsr[0] | lfsr[3]) : forceFull;
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(outValid == (expQ.size() > 0), "R8 valid", {15'd0, outValid}, {15'd0, expQ.size() > 0});
      check(evtReady == (expQ.size() == 0), "R9 ready", {15'd0, evtReady}, {15'd0, expQ.size() == 0});
      if (expQ.size() > 0 && outValid)
        check(outWord == expQ[0], tagQ[0], outWord, expQ[0]);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic sendEvent(input int ev, input logic [3:0] n, input logic [9:0] errs);
    @(negedge clk);
    cfgBuckets   = n;
    evtId        = 16'(ev * 16'h1357 + 3);
    evtCrossing  = 12'(ev * 291 + 17);
    evtState     = 2'(ev);
    for (int i = 0; i < 10; i++) evtSamples[i*16 +: 16] = 16'(ev * 4099 + i * 257 + 1);
    evtSampleErr = errs;
    evtSum       = 16'(ev * 771 + 9);
    evtAddr      = 15'(ev * 97 + 5);
    evtValid     = 1;
    do @(negedge clk); while (!lastAccept);
    evtValid     = 0;
    evtId        = 16'hFFFF;
    evtSamples   = '1;
    evtSum       = 16'hFFFF;
    evtSampleErr = '1;
    cfgBuckets   = 4'd2;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (expQ.size() != 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(outValid == 0, "R1 valid in reset", {15'd0, outValid}, 16'd0);
    check(evtReady == 1, "R1 ready in reset", {15'd0, evtReady}, 16'd1);
    rstN = 1;
    @(negedge clk);
    check(outValid == 0, "R1 valid after reset", {15'd0, outValid}, 16'd0);
    check(evtReady == 1, "R1 ready after reset", {15'd0, evtReady}, 16'd1);

    sendEvent(1, 4'd3, 10'b0);                 // R4 short fragment
    waitIdle();
    sendEvent(2, 4'd10, 10'b10_0000_0000);     // R7 error on last sample
    waitIdle();
    sendEvent(3, 4'd1, 10'b00_0001_0000);      // R7 masked error beyond N
    waitIdle();
    stallMode = 1;                             // R8 random stalls
    sendEvent(4, 4'd0, 10'b00_0010_0000);      // R5 zero clamps to ten
    waitIdle();
    sendEvent(5, 4'd12, 10'b0);                // R5 over-range clamps to ten
    waitIdle();
    sendEvent(6, 4'd7, 10'b00_0000_0001);
    sendEvent(7, 4'd2, 10'b0);                 // R9 held valid while busy
    waitIdle();
    stallMode = 0;
    forceFull = 1;                             // R8 long stall
    sendEvent(8, 4'd5, 10'b0);
    repeat (12) @(negedge clk);
    forceFull = 0;
    waitIdle();
    sendEvent(9, 4'd9, 10'b11_1111_1111);
    sendEvent(10, 4'd10, 10'b0);
    waitIdle();

    // R8 every expected word delivered exactly once
    check(pushed == popped, "R8 word count", 16'(popped), 16'(pushed));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule